// File: doc/BRIEF.md
# NOR Flash Command Sequencer

This block models the write-command interface of a byte-wide parallel NOR flash around a small on-chip byte array. Bus write cycles, marked by the rising edge of the write strobe while chip enable is low, are decoded by a multi-cycle unlock state machine into three operations: single-byte program, whole-array erase and sector erase. Sector erase opens an acceptance window. During the window more sectors can be added to an erase buffer, and each accepted addition restarts the window.

While an operation is in progress, reads return a status byte instead of array data. When the operation completes, the block goes back to array reads. Operation lengths are parameter-set clock-cycle counts. With the defaults the array is 2048 bytes in eight sectors of 256 bytes, and the top three address bits select the sector.

States and transitions. `ST_READ` moves to `ST_UNLK1` on 0xAA written to 0x555. `ST_UNLK1` moves to `ST_UNLK2` on 0x55 written to 0x2AA. From `ST_UNLK2`, 0xA0 written to 0x555 goes to `ST_PGM_LOAD`, and 0x80 written to 0x555 goes to `ST_SETUP`. `ST_PGM_LOAD` takes the next write as the target address and data, then moves to `ST_PROG`. `ST_SETUP` moves to `ST_UNLK3` on 0xAA written to 0x555. `ST_UNLK3` moves to `ST_UNLK4` on 0x55 written to 0x2AA. From `ST_UNLK4`, 0x10 written to 0x555 goes to `ST_ERASE` with every sector selected, and 0x30 written to any address goes to `ST_WINDOW` with that address's sector selected. `ST_PROG` returns to `ST_READ` when its timer expires. `ST_WINDOW` moves to `ST_ERASE` when its timer expires, and returns to `ST_READ` on any write other than 0x30 or 0xB0. `ST_ERASE` walks the whole array once and then returns to `ST_READ`. In every unlock or setup state, a write that does not match the expected cycle returns the machine to `ST_READ`.

Top module: `nor_cmd_seq`

## Requirements
- R1: After reset the block is in array-read mode, `op_busy` is 0 and every byte reads 0xFF.
- R2: The sequence 0xAA@0x555, 0x55@0x2AA, 0xA0@0x555, then data@address programs that byte. Addresses may be programmed in any order and in any sector, and the byte reads back after PROG_CYC cycles.
- R3: Programming only clears bits, so the stored byte becomes old AND new. Programming 0x0F and then 0xF0 at one address leaves 0x00.
- R4: While a program operation runs, `op_busy` is 1 and reads return status. Bit 7 is the complement of bit 7 of the written data, bit 6 inverts on every read, and bits 3 and 2 read 0.
- R5: While a program or an erase runs, bus writes are ignored. In particular, a complete program sequence written during an erase changes nothing.
- R6: The sequence 0xAA@0x555, 0x55@0x2AA, 0x80@0x555, 0xAA@0x555, 0x55@0x2AA, 0x10@0x555 sets every byte to 0xFF.
- R7: The same first five cycles followed by 0x30 at any address erase only the sector named by address bits [10:8]. Sectors added during the window are erased as well, and all other bytes keep their values.
- R8: During the acceptance window `op_busy` is 1 and status bit 3 reads 0. Each 0x30 write inside the window adds a sector and restarts the WIN_CYC count.
- R9: Any write during the window other than 0x30 or 0xB0 empties the sector buffer and returns to array-read mode without erasing.
- R10: A write that does not match the expected unlock, setup or command cycle returns the decoder to array-read mode. Later writes are then not taken as part of the abandoned sequence.
- R11: During the erase itself, status bit 7 reads 0 and bit 3 reads 1, and bits 6 and 2 both invert on every read.
- R12: A 0xB0 write during the window is accepted and leaves the window and its buffer as they were.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all strobes are sampled on its rising edge |
| rst_n | input | 1 | Active-low reset; the array is filled with 0xFF |
| bus_ce_n | input | 1 | Chip enable, active low |
| bus_we_n | input | 1 | Write strobe, active low; the write is taken on its rising edge |
| bus_oe_n | input | 1 | Read strobe, active low; each falling edge counts as one read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Array data in read mode, status byte while busy |
| op_busy | output | 1 | High during program, window and erase |

## Verification
The array is swept in full three times. The first sweep, after reset, separates a correct reset fill from stale content. The second, after a three-sector erase, compares each byte with a bench model and so tells erased sectors apart from neighbours that were programmed. The third, after a chip erase, also catches a program sequence written during the erase that should have been ignored. Short command sequences that are deliberately broken at the third, fifth and window cycles tell a true abort apart from a decoder that keeps going. Status reads taken before and after the original window deadline tell a restarted window apart from one that expires on schedule.

// File: rtl/nor_seq_pkg.sv
package nor_seq_pkg;

    typedef enum logic [3:0] {
        ST_READ,
        ST_UNLK1,
        ST_UNLK2,
        ST_PGM_LOAD,
        ST_SETUP,
        ST_UNLK3,
        ST_UNLK4,
        ST_PROG,
        ST_WINDOW,
        ST_ERASE
    } seq_state_t;

    localparam logic [7:0]  CMD_KEY_A  = 8'hAA;
    localparam logic [7:0]  CMD_KEY_B  = 8'h55;
    localparam logic [7:0]  CMD_SETUP  = 8'h80;
    localparam logic [7:0]  CMD_PGM    = 8'hA0;
    localparam logic [7:0]  CMD_CHIP   = 8'h10;
    localparam logic [7:0]  CMD_SECT   = 8'h30;
    localparam logic [7:0]  CMD_SUSP   = 8'hB0;
    localparam logic [10:0] ADR_KEY_A  = 11'h555;
    localparam logic [10:0] ADR_KEY_B  = 11'h2AA;

endpackage

// File: rtl/nor_bus_sync.sv
module nor_bus_sync #(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic              wr_stb,
    output logic              rd_stb,
    output logic [ADDR_W-1:0] addr_q,
    output logic [7:0]        data_q
);
    logic ce_q, we_q, oe_q, we_d, oe_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ce_q   <= 1'b1;
            we_q   <= 1'b1;
            oe_q   <= 1'b1;
            we_d   <= 1'b1;
            oe_d   <= 1'b1;
            addr_q <= '0;
            data_q <= '0;
        end else begin
            ce_q   <= ce_n;
            we_q   <= we_n;
            oe_q   <= oe_n;
            we_d   <= we_q;
            oe_d   <= oe_q;
            addr_q <= addr;
            data_q <= wdata;
        end
    end

    assign wr_stb = we_q & ~we_d & ~ce_q;
    assign rd_stb = ~oe_q & oe_d & ~ce_q;
endmodule

// File: rtl/nor_cyc_timer.sv
module nor_cyc_timer #(
    parameter int TMR_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [TMR_W-1:0] load_val,
    output logic             zero
);
    logic [TMR_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt <= '0;
        else if (load)       cnt <= load_val;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/nor_byte_array.sv
module nor_byte_array #(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [7:0]        wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [7:0]        rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
            rdata <= 8'hFF;
        end else begin
            if (we) mem[waddr] <= wdata;
            rdata <= mem[raddr];
        end
    end
endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
    import nor_seq_pkg::*;
#(
    parameter int ADDR_W    = 11,
    parameter int SECT_BITS = 3,
    parameter int WIN_CYC   = 100,
    parameter int PROG_CYC  = 20,
    parameter int TMR_W     = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_ce_n,
    input  logic              bus_we_n,
    input  logic              bus_oe_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic              op_busy
);
    localparam int NSECT = 1 << SECT_BITS;

    seq_state_t state, nxt;

    logic              wr_stb, rd_stb;
    logic [ADDR_W-1:0] a_q;
    logic [7:0]        d_q;
    logic [ADDR_W-1:0] pa;
    logic [7:0]        pd;
    logic [NSECT-1:0]  sect_buf, sect_hit;
    logic [ADDR_W-1:0] er_ptr;
    logic              er_last;
    logic              tog;
    logic              tmr_load, tmr_zero;
    logic [TMR_W-1:0]  tmr_val;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_waddr, mem_raddr;
    logic [7:0]        mem_wdata, mem_rdata;
    logic              key_a, key_b, at_a;
    logic              win_add, win_keep;

    nor_bus_sync #(.ADDR_W(ADDR_W)) u_sync (
        .clk(clk), .rst_n(rst_n), .ce_n(bus_ce_n), .we_n(bus_we_n),
        .oe_n(bus_oe_n), .addr(bus_addr), .wdata(bus_wdata),
        .wr_stb(wr_stb), .rd_stb(rd_stb), .addr_q(a_q), .data_q(d_q)
    );

    nor_cyc_timer #(.TMR_W(TMR_W)) u_tmr (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val),
        .zero(tmr_zero)
    );

    nor_byte_array #(.ADDR_W(ADDR_W)) u_arr (
        .clk(clk), .rst_n(rst_n), .we(mem_we), .waddr(mem_waddr),
        .wdata(mem_wdata), .raddr(mem_raddr), .rdata(mem_rdata)
    );

    // cycle matching
    assign at_a    = (a_q[10:0] == ADR_KEY_A);
    assign key_a   = at_a && (d_q == CMD_KEY_A);
    assign key_b   = (a_q[10:0] == ADR_KEY_B) && (d_q == CMD_KEY_B);
    assign er_last = (er_ptr == {ADDR_W{1'b1}});
    assign win_add  = (state == ST_WINDOW) && !tmr_zero && wr_stb && (d_q == CMD_SECT);
    assign win_keep = (state == ST_WINDOW) && !tmr_zero && wr_stb && (d_q == CMD_SUSP);

    always_comb begin
        sect_hit = '0;
        sect_hit[a_q[ADDR_W-1 -: SECT_BITS]] = 1'b1;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_READ;
        else        state <= nxt;
    end

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            ST_READ:     if (wr_stb && key_a) nxt = ST_UNLK1;
            ST_UNLK1:    if (wr_stb) nxt = key_b ? ST_UNLK2 : ST_READ;
            ST_UNLK2:    if (wr_stb) begin
                             if (at_a && d_q == CMD_PGM)        nxt = ST_PGM_LOAD;
                             else if (at_a && d_q == CMD_SETUP) nxt = ST_SETUP;
                             else                               nxt = ST_READ;
                         end
            ST_PGM_LOAD: if (wr_stb) nxt = ST_PROG;
            ST_SETUP:    if (wr_stb) nxt = key_a ? ST_UNLK3 : ST_READ;
            ST_UNLK3:    if (wr_stb) nxt = key_b ? ST_UNLK4 : ST_READ;
            ST_UNLK4:    if (wr_stb) begin
                             if (at_a && d_q == CMD_CHIP)  nxt = ST_ERASE;
                             else if (d_q == CMD_SECT)     nxt = ST_WINDOW;
                             else                          nxt = ST_READ;
                         end
            ST_PROG:     if (tmr_zero) nxt = ST_READ;
            ST_WINDOW:   if (tmr_zero) nxt = ST_ERASE;
                         else if (wr_stb && !win_add && !win_keep) nxt = ST_READ;
            ST_ERASE:    if (er_last) nxt = ST_READ;
            default:     nxt = ST_READ;
        endcase
    end

    // outputs of the machine
    always_comb begin
        tmr_load  = 1'b0;
        tmr_val   = '0;
        mem_we    = 1'b0;
        mem_waddr = er_ptr;
        mem_wdata = 8'hFF;
        mem_raddr = a_q;
        op_busy   = 1'b0;
        bus_rdata = mem_rdata;
        unique case (state)
            ST_PGM_LOAD: if (wr_stb) begin
                             tmr_load = 1'b1;
                             tmr_val  = TMR_W'(PROG_CYC);
                         end
            ST_UNLK4:    if (wr_stb && d_q == CMD_SECT && !(at_a && d_q == CMD_CHIP)) begin
                             tmr_load = 1'b1;
                             tmr_val  = TMR_W'(WIN_CYC);
                         end
            ST_PROG:     begin
                             op_busy   = 1'b1;
                             mem_raddr = pa;
                             mem_waddr = pa;
                             mem_wdata = mem_rdata & pd;
                             mem_we    = tmr_zero;
                             bus_rdata = {~pd[7], tog, 2'b00, 1'b0, 1'b0, 2'b00};
                         end
            ST_WINDOW:   begin
                             op_busy   = 1'b1;
                             tmr_load  = win_add;
                             tmr_val   = TMR_W'(WIN_CYC);
                             bus_rdata = {1'b0, tog, 2'b00, 1'b0, tog, 2'b00};
                         end
            ST_ERASE:    begin
                             op_busy   = 1'b1;
                             mem_we    = sect_buf[er_ptr[ADDR_W-1 -: SECT_BITS]];
                             bus_rdata = {1'b0, tog, 2'b00, 1'b1, tog, 2'b00};
                         end
            default:     ;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pa       <= '0;
            pd       <= '0;
            sect_buf <= '0;
            er_ptr   <= '0;
            tog      <= 1'b0;
        end else begin
            if (state == ST_PGM_LOAD && wr_stb) begin
                pa <= a_q;
                pd <= d_q;
            end

            if (state == ST_UNLK4 && wr_stb) begin
                if (at_a && d_q == CMD_CHIP) sect_buf <= '1;
                else if (d_q == CMD_SECT)    sect_buf <= sect_hit;
            end else if (state == ST_WINDOW && !tmr_zero && wr_stb) begin
                if (win_add)        sect_buf <= sect_buf | sect_hit;
                else if (!win_keep) sect_buf <= '0;
            end else if (state == ST_ERASE && er_last) begin
                sect_buf <= '0;
            end

            if (state == ST_ERASE) er_ptr <= er_ptr + 1'b1;
            else                   er_ptr <= '0;

            if (!op_busy)    tog <= 1'b0;
            else if (rd_stb) tog <= ~tog;
        end
    end
endmodule

// File: rtl/nor_cmd_seq_chk.sv
module nor_cmd_seq_chk
    import nor_seq_pkg::*;
#(
    parameter int SECT_BITS = 3
) (
    input logic                     clk,
    input logic                     rst_n,
    input seq_state_t               state,
    input logic                     rd_stb,
    input logic                     tmr_zero,
    input logic                     mem_we,
    input logic [7:0]               mem_wdata,
    input logic [7:0]               mem_rdata,
    input logic [(1<<SECT_BITS)-1:0] sect_buf,
    input logic                     tog,
    input logic                     op_busy
);
    AST_PROG_CLEARS_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && state == ST_PROG) |-> ((mem_wdata & ~mem_rdata) == 8'h00)); // R3

    AST_PROG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PROG && !tmr_zero) |=> (state == ST_PROG)); // R5

    AST_ERASE_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && state == ST_ERASE) |-> (mem_wdata == 8'hFF)); // R6

    AST_WINDOW_EXPIRES: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WINDOW && tmr_zero) |=> (state == ST_ERASE)); // R8

    AST_BUF_EMPTY_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_READ) |-> (sect_buf == '0)); // R9

    AST_STATUS_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && op_busy) |=> (tog != $past(tog))); // R4
endmodule

bind nor_cmd_seq nor_cmd_seq_chk #(.SECT_BITS(SECT_BITS)) u_chk (
    .clk(clk), .rst_n(rst_n), .state(state), .rd_stb(rd_stb),
    .tmr_zero(tmr_zero), .mem_we(mem_we), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .sect_buf(sect_buf), .tog(tog), .op_busy(op_busy)
);

// File: tb/nor_cmd_seq_tb_top.sv
module nor_cmd_seq_tb_top;
    localparam int AW    = 11;
    localparam int DEPTH = 1 << AW;
    localparam int WIN   = 100;
    localparam int PROG  = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [7:0]    wdata = '0;
    logic [7:0]    rdata;
    logic          busy;

    int tests = 0;
    int fails = 0;
    logic [7:0] exp_mem [DEPTH];

    always #4 clk = ~clk;

    nor_cmd_seq #(.ADDR_W(AW), .SECT_BITS(3), .WIN_CYC(WIN), .PROG_CYC(PROG)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_ce_n(ce_n), .bus_we_n(we_n),
        .bus_oe_n(oe_n), .bus_addr(addr), .bus_wdata(wdata),
        .bus_rdata(rdata), .op_busy(busy)
    );

    task automatic chk(input string what, input logic [7:0] act, input logic [7:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", what, act, exp);
        end
    endtask

    task automatic bus_write(input logic [AW-1:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; ce_n = 1'b0; we_n = 1'b0;
        repeat (2) @(negedge clk);
        we_n = 1'b1;
        repeat (2) @(negedge clk);
        ce_n = 1'b1;
    endtask

    task automatic bus_read(input logic [AW-1:0] a, output logic [7:0] v);
        @(negedge clk);
        addr = a; ce_n = 1'b0; oe_n = 1'b0;
        repeat (4) @(negedge clk);
        v = rdata;
        oe_n = 1'b1; ce_n = 1'b1;
    endtask

    task automatic pgm_seq(input logic [AW-1:0] a, input logic [7:0] d);
        bus_write(11'h555, 8'hAA);
        bus_write(11'h2AA, 8'h55);
        bus_write(11'h555, 8'hA0);
        bus_write(a, d);
    endtask

    task automatic erase_prefix();
        bus_write(11'h555, 8'hAA);
        bus_write(11'h2AA, 8'h55);
        bus_write(11'h555, 8'h80);
        bus_write(11'h555, 8'hAA);
        bus_write(11'h2AA, 8'h55);
    endtask

    task automatic program_byte(input logic [AW-1:0] a, input logic [7:0] d);
        pgm_seq(a, d);
        repeat (PROG + 8) @(negedge clk);
        exp_mem[a] = exp_mem[a] & d;
    endtask

    task automatic sweep(input string tag);
        logic [7:0] v;
        for (int a = 0; a < DEPTH; a++) begin
            bus_read(AW'(a), v);
            chk($sformatf("%s addr=%h", tag, a), v, exp_mem[a]);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [7:0] v, v2;
        for (int i = 0; i < DEPTH; i++) exp_mem[i] = 8'hFF;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R1 reset state
        chk("R1 busy after reset", {7'd0, busy}, 8'h00);
        sweep("R1 reset fill");

        // R4 status during program, R2 completion
        pgm_seq(11'h1A3, 8'h5C);
        chk("R4 busy in program", {7'd0, busy}, 8'h01);
        bus_read(11'h000, v);
        bus_read(11'h000, v2);
        chk("R4 dq7 complement", {7'd0, v[7]}, {7'd0, ~1'b0});
        chk("R4 dq3 dq2 zero", {6'd0, v[3], v[2]}, 8'h00);
        chk("R4 dq6 toggles", {7'd0, v[6] ^ v2[6]}, 8'h01);
        repeat (PROG + 8) @(negedge clk);
        exp_mem[11'h1A3] = 8'h5C;
        chk("R4 busy clear", {7'd0, busy}, 8'h00);
        bus_read(11'h1A3, v);
        chk("R2 first byte", v, 8'h5C);

        // R2 scattered programming across sectors
        for (int i = 0; i < 24; i++)
            program_byte(AW'((i * 89 + 3) % DEPTH), 8'((i * 53 + 11) & 8'hFF));
        program_byte(11'h210, 8'h3C);
        program_byte(11'h0A0, 8'h00);
        for (int i = 0; i < 24; i++) begin
            bus_read(AW'((i * 89 + 3) % DEPTH), v);
            chk("R2 readback", v, exp_mem[(i * 89 + 3) % DEPTH]);
        end

        // R3 bits only clear
        program_byte(11'h5A5, 8'h0F);
        program_byte(11'h5A5, 8'hF0);
        bus_read(11'h5A5, v);
        chk("R3 and of writes", v, 8'h00);

        // R10 broken sequence at the third cycle
        bus_write(11'h555, 8'hAA);
        bus_write(11'h2AA, 8'h55);
        bus_write(11'h555, 8'h12);
        bus_write(11'h050, 8'h00);
        repeat (PROG + 8) @(negedge clk);
        chk("R10 no busy", {7'd0, busy}, 8'h00);
        bus_read(11'h050, v);
        chk("R10 byte untouched", v, exp_mem[11'h050]);
        // R10 broken at the fifth cycle
        bus_write(11'h555, 8'hAA);
        bus_write(11'h2AA, 8'h55);
        bus_write(11'h555, 8'h80);
        bus_write(11'h555, 8'hAA);
        bus_write(11'h2AA, 8'h77);
        bus_write(11'h555, 8'h10);
        chk("R10 no chip erase", {7'd0, busy}, 8'h00);

        // R9 abort window
        erase_prefix();
        bus_write(11'h200, 8'h30);
        chk("R9 window entered", {7'd0, busy}, 8'h01);
        bus_write(11'h000, 8'hF0);
        chk("R9 aborted", {7'd0, busy}, 8'h00);
        repeat (WIN + 50) @(negedge clk);
        bus_read(11'h210, v);
        chk("R9 sector kept", v, 8'h3C);

        // R8 R12 R11 R5 R7 sector erase with buffer
        erase_prefix();
        bus_write(11'h123, 8'h30);
        bus_read(11'h000, v);
        chk("R8 busy in window", {7'd0, busy}, 8'h01);
        chk("R8 dq3 low in window", {7'd0, v[3]}, 8'h00);
        bus_write(11'h000, 8'hB0);
        chk("R12 window kept", {7'd0, busy}, 8'h01);
        repeat (50) @(negedge clk);
        bus_write(11'h400, 8'h30);
        bus_write(11'h650, 8'h30);
        repeat (40) @(negedge clk);
        bus_read(11'h000, v);
        chk("R8 restarted dq3", {7'd0, v[3]}, 8'h00);
        chk("R8 restarted busy", {7'd0, busy}, 8'h01);
        repeat (80) @(negedge clk);
        bus_read(11'h000, v);
        bus_read(11'h000, v2);
        chk("R11 dq3 high", {7'd0, v[3]}, 8'h01);
        chk("R11 dq7 zero", {7'd0, v[7]}, 8'h00);
        chk("R11 dq6 toggles", {7'd0, v[6] ^ v2[6]}, 8'h01);
        chk("R11 dq2 toggles", {7'd0, v[2] ^ v2[2]}, 8'h01);
        pgm_seq(11'h033, 8'h00);
        repeat (2300) @(negedge clk);
        chk("R7 erase done", {7'd0, busy}, 8'h00);
        for (int a = 0; a < DEPTH; a++)
            if ((a >> 8) == 1 || (a >> 8) == 4 || (a >> 8) == 6) exp_mem[a] = 8'hFF;
        sweep("R7 R5 after sector erase");

        // R6 chip erase with R5 injection
        erase_prefix();
        bus_write(11'h555, 8'h10);
        chk("R6 busy", {7'd0, busy}, 8'h01);
        pgm_seq(11'h077, 8'h00);
        repeat (2300) @(negedge clk);
        chk("R6 done", {7'd0, busy}, 8'h00);
        for (int a = 0; a < DEPTH; a++) exp_mem[a] = 8'hFF;
        sweep("R6 R5 after chip erase");

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule